// File: doc/BRIEF.md
# EEPROM Image Checksum Verifier and Repairer

This block checks the integrity word at the end of the checksum region of an attached EEPROM image and, if asked to, repairs it. On a start pulse it walks the region one byte at a time through a byte-read request port, starting at byte 0. It pairs the bytes into little-endian 16-bit words and keeps a 16-bit wrapping sum of every word below the checksum slot. It also captures the word held in that slot. The required checksum is a target constant minus that sum.

When the stored word equals the required one, the run ends with a pass. When it differs, the run ends with a fail. If the update input was high at start, the block first issues one word-write request that puts the corrected value into the slot. The write is addressed at the slot's low byte, and the word is laid down low byte first. An error strobe from the transfer side ends any run at once with an error flag.

The controller is a four-state machine:
- IDLE waits for start. IDLE to READ is taken on start.
- READ issues byte reads. READ to CHECK is taken on the last byte. READ to IDLE is taken on an error.
- CHECK compares the two words. CHECK to IDLE is taken on a match, or on a mismatch with update low. CHECK to WRITE is taken on a mismatch with update high.
- WRITE issues the repair write. WRITE to IDLE is taken on write completion or on an error.

Top module: `eep_csum_fixer`

## Requirements
- R1: After reset the block is in IDLE with busy, done, pass, fail, err, mem_rd_req and mem_wr_req all low.
- R2: A start pulse in IDLE begins a run that requests bytes at addresses 0, 1, 2, … up to (CSUM_IDX+1)*2-1, one address per accepted byte (a cycle with mem_rd_valid high), in ascending order. A start while busy has no effect.
- R3: Word k of the image is {byte[2k+1], byte[2k]}, so the byte at the even address is the low half.
- R4: calc_word equals CSUM_TARGET minus the modulo-65536 sum of words 0 to CSUM_IDX-1. stored_word equals word CSUM_IDX.
- R5: When stored_word equals calc_word, the run ends with done and pass high, fail low, and no write request.
- R6: On a mismatch with update low at start, the run ends with done and fail high, pass low, and no write request.
- R7: On a mismatch with update high at start, exactly one write request is issued. It carries mem_addr = CSUM_IDX*2 and mem_wr_word = calc_word, whose bits 7..0 belong at that address and bits 15..8 at the next. mem_wr_req and mem_wr_word stay steady until mem_wr_done. The run then ends with done and fail high.
- R8: mem_err during READ or WRITE ends the run at that edge with done and err high and pass and fail low. An error in the same cycle as an accepted byte wins over that byte.
- R9: busy is high from the cycle after start until the run ends, and never together with done. done, pass, fail and err hold their values until the next start.
- R10: The sum is cleared at every start, so each run's result depends only on the image it reads.
- R11: mem_rd_req and mem_wr_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled in IDLE) |
| update | input | 1 | Repair on mismatch (sampled with start) |
| mem_rd_req | output | 1 | Byte-read request, held until a byte is accepted |
| mem_addr | output | ADDR_W | Byte address of the read or write |
| mem_rd_valid | input | 1 | Requested byte is on mem_rd_data |
| mem_rd_data | input | 8 | Read byte |
| mem_wr_req | output | 1 | Word-write request |
| mem_wr_word | output | 16 | Word to write, low byte at mem_addr |
| mem_wr_done | input | 1 | Write completed |
| mem_err | input | 1 | Transfer error strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| pass | output | 1 | Stored checksum was correct |
| fail | output | 1 | Stored checksum was wrong |
| err | output | 1 | Run aborted by a transfer error |
| stored_word | output | 16 | Word read from the checksum slot |
| calc_word | output | 16 | Required checksum value |

## Verification
Two events can fall in the same cycle: the acceptance of a byte and a transfer error. The bench's memory model raises the error strobe together with the valid strobe at a chosen byte address. It sweeps that address over every byte of the region, including the final one that would otherwise move the machine to CHECK. For each case the error flag must be set, pass and fail must stay low, and the image must be unchanged. The same collision is provoked between write completion and an error, and a second start is pulsed in the middle of a run to confirm it does not restart the walk.

// File: rtl/eep_csum_pkg.sv
package eep_csum_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_CHECK = 2'd2,
        ST_WRITE = 2'd3
    } csum_state_t;

    typedef logic [15:0] csum_word_t;
endpackage

// File: rtl/eep_byte_ctr.sv
module eep_byte_ctr #(
    parameter int ADDR_W   = 16,
    parameter int LAST_IDX = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] cnt,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_A);
endmodule

// File: rtl/eep_word_accum.sv
module eep_word_accum
    import eep_csum_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CSUM_IDX = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic [ADDR_W-1:0] byte_addr,
    output csum_word_t        sum,
    output csum_word_t        stored
);
    localparam logic [ADDR_W-1:0] SLOT_HI = ADDR_W'(CSUM_IDX * 2 + 1);

    logic [7:0] lo_q;
    csum_word_t word;

    // low byte arrives first at the even address
    assign word = {byte_in, lo_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            sum    <= '0;
            stored <= '0;
        end else if (clr) begin
            lo_q   <= '0;
            sum    <= '0;
            stored <= '0;
        end else if (byte_vld) begin
            if (!byte_addr[0])
                lo_q <= byte_in;
            else if (byte_addr == SLOT_HI)
                stored <= word;
            else
                sum <= sum + word;
        end
    end
endmodule

// File: rtl/eep_csum_fixer.sv
module eep_csum_fixer
    import eep_csum_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          CSUM_IDX    = 63,
    parameter logic [15:0] CSUM_TARGET = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              update,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rd_valid,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_req,
    output logic [15:0]       mem_wr_word,
    input  logic              mem_wr_done,
    input  logic              mem_err,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic              err,
    output logic [15:0]       stored_word,
    output logic [15:0]       calc_word
);
    localparam int                LAST_IDX = (CSUM_IDX + 1) * 2 - 1;
    localparam logic [ADDR_W-1:0] SLOT_LO  = ADDR_W'(CSUM_IDX * 2);

    csum_state_t       state, nxt;
    logic              upd_q;
    logic              go, take, last;
    logic [ADDR_W-1:0] cnt;
    csum_word_t        sum;
    logic              match;

    assign go   = (state == ST_IDLE) && start;
    assign take = (state == ST_READ) && mem_rd_valid && !mem_err;

    eep_byte_ctr #(.ADDR_W(ADDR_W), .LAST_IDX(LAST_IDX)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(go), .inc(take), .cnt(cnt), .last(last)
    );

    eep_word_accum #(.ADDR_W(ADDR_W), .CSUM_IDX(CSUM_IDX)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(go), .byte_vld(take),
        .byte_in(mem_rd_data), .byte_addr(cnt), .sum(sum), .stored(stored_word)
    );

    assign calc_word = CSUM_TARGET - sum;
    assign match     = (stored_word == calc_word);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_READ;
            ST_READ:  if (mem_err) nxt = ST_IDLE;
                      else if (mem_rd_valid && last) nxt = ST_CHECK;
            ST_CHECK: nxt = (!match && upd_q) ? ST_WRITE : ST_IDLE;
            ST_WRITE: if (mem_err || mem_wr_done) nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // registered result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
            done  <= 1'b0;
            pass  <= 1'b0;
            fail  <= 1'b0;
            err   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    upd_q <= update;
                    done  <= 1'b0;
                    pass  <= 1'b0;
                    fail  <= 1'b0;
                    err   <= 1'b0;
                end
                ST_READ: if (mem_err) begin
                    done <= 1'b1;
                    err  <= 1'b1;
                end
                ST_CHECK: if (match || !upd_q) begin
                    done <= 1'b1;
                    pass <= match;
                    fail <= !match;
                end
                ST_WRITE: if (mem_err) begin
                    done <= 1'b1;
                    err  <= 1'b1;
                end else if (mem_wr_done) begin
                    done <= 1'b1;
                    fail <= 1'b1;
                end
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign mem_rd_req  = (state == ST_READ);
    assign mem_wr_req  = (state == ST_WRITE);
    assign mem_addr    = (state == ST_WRITE) ? SLOT_LO : cnt;
    assign mem_wr_word = calc_word;
endmodule

// File: rtl/eep_csum_fixer_chk.sv
module eep_csum_fixer_chk #(
    parameter int ADDR_W   = 16,
    parameter int CSUM_IDX = 63
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_wr_req,
    input logic [15:0]       mem_wr_word,
    input logic              mem_wr_done,
    input logic              mem_err,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic              err,
    input logic [15:0]       stored_word,
    input logic [15:0]       calc_word
);
    localparam logic [ADDR_W-1:0] SLOT_LO = ADDR_W'(CSUM_IDX * 2);
    localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'((CSUM_IDX + 1) * 2 - 1);

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)); // R11
    AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R9
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones({pass, fail, err}) == 1); // R8
    AST_PASS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> stored_word == calc_word); // R5
    AST_WR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> mem_addr == SLOT_LO); // R7
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_done && !mem_err) |=> (mem_wr_req && $stable(mem_wr_word))); // R7
    AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> mem_addr <= LAST_A); // R2
    AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd_req || mem_wr_req) && mem_err) |=> (!busy && err)); // R8
endmodule

bind eep_csum_fixer eep_csum_fixer_chk #(.ADDR_W(ADDR_W), .CSUM_IDX(CSUM_IDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd_req(mem_rd_req), .mem_addr(mem_addr),
    .mem_wr_req(mem_wr_req), .mem_wr_word(mem_wr_word), .mem_wr_done(mem_wr_done),
    .mem_err(mem_err), .busy(busy), .done(done), .pass(pass), .fail(fail),
    .err(err), .stored_word(stored_word), .calc_word(calc_word)
);

// File: tb/eep_csum_fixer_bench.sv
module eep_csum_fixer_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 8;
    localparam int          IDX        = 3;
    localparam logic [15:0] TGT        = 16'hBABA;
    localparam int          NBYTES     = (IDX + 1) * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, update = 1'b0;
    logic mem_rd_req, mem_wr_req, busy, done, pass, fail, err;
    logic [AW-1:0] mem_addr;
    logic mem_rd_valid = 1'b0, mem_wr_done = 1'b0, mem_err = 1'b0;
    logic [7:0] mem_rd_data = '0;
    logic [15:0] mem_wr_word, stored_word, calc_word;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eep_csum_fixer #(.ADDR_W(AW), .CSUM_IDX(IDX), .CSUM_TARGET(TGT)) u_eep_csum_fixer (
        .clk(clk), .rst_n(rst_n), .start(start), .update(update),
        .mem_rd_req(mem_rd_req), .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_word(mem_wr_word),
        .mem_wr_done(mem_wr_done), .mem_err(mem_err), .busy(busy), .done(done),
        .pass(pass), .fail(fail), .err(err), .stored_word(stored_word), .calc_word(calc_word)
    );

    int tests = 0, fails = 0;
    logic [7:0] img [NBYTES];
    int err_rd_at = -1;
    bit err_on_wr = 0;
    int n_reads = 0, n_order_bad = 0, n_writes = 0;

    // memory model: one byte every other cycle, writes take one cycle
    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        mem_wr_done  <= 1'b0;
        mem_err      <= 1'b0;
        if (mem_rd_req && !mem_rd_valid) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= img[int'(mem_addr)];
            if (int'(mem_addr) != n_reads) n_order_bad <= n_order_bad + 1;
            n_reads <= n_reads + 1;
            if (int'(mem_addr) == err_rd_at) mem_err <= 1'b1;
        end
        if (mem_wr_req && !mem_wr_done) begin
            mem_wr_done <= 1'b1;
            n_writes    <= n_writes + 1;
            if (err_on_wr) mem_err <= 1'b1;
            else begin
                img[int'(mem_addr)]     <= mem_wr_word[7:0];
                img[int'(mem_addr) + 1] <= mem_wr_word[15:8];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input int k);
        return {img[2*k+1], img[2*k]};
    endfunction

    function automatic logic [15:0] exp_calc();
        logic [15:0] s = '0;
        for (int k = 0; k < IDX; k++) s = s + word_of(k);
        return TGT - s;
    endfunction

    task automatic run(input bit upd, input bit restart_mid);
        @(negedge clk);
        n_reads = 0; n_order_bad = 0; n_writes = 0;
        start = 1'b1; update = upd;
        @(negedge clk);
        start = 1'b0; update = 1'b0;
        chk(busy === 1'b1, "R9 busy after start", busy, 1);
        if (restart_mid) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0, "R9 run ends", {busy, done}, 2'b01);
    endtask

    task automatic quiet_check();
        int reqs = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (mem_rd_req || mem_wr_req || busy) reqs++;
        end
        chk(reqs == 0 && done, "R9 idle after done, flags held", reqs, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] c, old;
        logic [7:0]  snap [NBYTES];
        for (int b = 0; b < NBYTES; b++) img[b] = 8'(b * 37 + 5);
        repeat (3) @(negedge clk);
        chk({busy, done, pass, fail, err, mem_rd_req, mem_wr_req} === 7'b0, "R1 reset state",
            {busy, done, pass, fail, err, mem_rd_req, mem_wr_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, mem_rd_req, mem_wr_req} === 4'b0, "R1 idle after reset", busy, 0);

        // sweep of images: correct, wrong-no-update, wrong-update
        for (int t = 0; t < 60; t++) begin
            int mode = t % 3;
            for (int b = 0; b < NBYTES; b++) img[b] = 8'($urandom);
            if (t == 3) for (int b = 0; b < NBYTES; b++) img[b] = 8'hFF;
            c = exp_calc();
            if (mode == 0) begin img[2*IDX] = c[7:0]; img[2*IDX+1] = c[15:8]; end
            else if (word_of(IDX) == c) img[2*IDX] = img[2*IDX] ^ 8'h01;
            old = word_of(IDX);
            run(mode == 2, 1'b0);
            chk(n_reads == NBYTES && n_order_bad == 0, "R2 ascending byte walk", n_reads, NBYTES);
            chk(calc_word === c, "R4 calc value", calc_word, c);
            chk(stored_word === old, "R3 little-endian stored word", stored_word, old);
            if (mode == 0) begin
                chk(pass && !fail && !err, "R5 pass", {pass, fail, err}, 3'b100);
                chk(n_writes == 0, "R5 no write", n_writes, 0);
            end else if (mode == 1) begin
                chk(fail && !pass && !err, "R6 fail", {pass, fail, err}, 3'b010);
                chk(n_writes == 0 && word_of(IDX) == old, "R6 no write", word_of(IDX), old);
            end else begin
                chk(fail && !pass && !err, "R7 fail after repair", {pass, fail, err}, 3'b010);
                chk(n_writes == 1, "R7 single write", n_writes, 1);
                chk(img[2*IDX] == c[7:0] && img[2*IDX+1] == c[15:8], "R7 slot low byte first",
                    word_of(IDX), c);
                // R10 independent second run sees repaired image
                run(1'b0, 1'b0);
                chk(pass && calc_word === c, "R10 rerun after repair passes", calc_word, c);
            end
        end
        quiet_check();

        // start while busy is ignored
        c = exp_calc();
        run(1'b0, 1'b1);
        chk(n_reads == NBYTES && n_order_bad == 0, "R2 start while busy ignored", n_reads, NBYTES);

        // error coinciding with every accepted byte position
        for (int e = 0; e < NBYTES; e++) begin
            for (int b = 0; b < NBYTES; b++) img[b] = 8'($urandom);
            if (word_of(IDX) == exp_calc()) img[2*IDX] = img[2*IDX] ^ 8'h01;
            for (int b = 0; b < NBYTES; b++) snap[b] = img[b];
            err_rd_at = e;
            run(1'b1, 1'b0);
            err_rd_at = -1;
            chk(err && !pass && !fail, "R8 read error wins", {pass, fail, err}, 3'b001);
            chk(n_reads == e + 1 && n_writes == 0, "R8 no further requests", n_reads, e + 1);
            chk(img[2*IDX] == snap[2*IDX] && img[2*IDX+1] == snap[2*IDX+1], "R8 image unchanged",
                word_of(IDX), {snap[2*IDX+1], snap[2*IDX]});
        end

        // error with write completion
        for (int b = 0; b < NBYTES; b++) img[b] = 8'($urandom);
        if (word_of(IDX) == exp_calc()) img[2*IDX] = img[2*IDX] ^ 8'h01;
        old = word_of(IDX);
        err_on_wr = 1'b1;
        run(1'b1, 1'b0);
        err_on_wr = 1'b0;
        chk(err && !pass && !fail, "R8 write error", {pass, fail, err}, 3'b001);
        chk(n_writes == 1 && word_of(IDX) == old, "R8 write error slot unchanged", word_of(IDX), old);
        quiet_check();

        // R10: all-zero image after a nonzero run
        for (int b = 0; b < NBYTES; b++) img[b] = 8'h00;
        run(1'b0, 1'b0);
        chk(calc_word === TGT && fail, "R10 sum cleared at start", calc_word, TGT);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule